// File: doc/BRIEF.md
# Indexed Colour Palette Loader and Lookup

This block keeps a colour lookup table of 256 entries, each entry holding an 8-bit red, an 8-bit green and an 8-bit blue value. Software fills the table through a small register window: an entry pointer register picks the entry, and a colour port register takes component bytes. A component sequencer sends each byte to red, then green, then blue. After blue it moves the pointer on to the next entry, so a whole table can be streamed in with no further pointer writes.

A separate pixel port turns an 8-bit pixel code into a packed 24-bit colour, with one cycle of registered latency. Every colour port write raises a redraw request, so the display side knows that pixels already on screen may now show stale colours. The display side drops the request with a clear strobe. A 32-bit colour write carries four components. They are applied one per clock, and the bus ready is held low until the last one is done.

Top module: `clut_dac`

## Requirements
- R1: A write to offset 0x00 loads the entry pointer from wdata[7:0] and returns the component phase to red. The write completes in the cycle it is presented.
- R2: A byte-wide write (bus_wide=0) to offset 0x04 carries one component in wdata[7:0]. It lands in the component of the current entry that the phase selects, and wdata[31:8] is ignored.
- R3: Components are stored in the order red, green, blue. The phase moves from red to green and from green to blue after each component.
- R4: After a blue component the entry pointer increments modulo 256 (255 wraps to 0) and the phase returns to red.
- R5: A 32-bit write (bus_wide=1) to offset 0x04 carries four components, taken wdata[31:24] first, then [23:16], [15:8] and [7:0]. Each one steps the sequencer as in R3 and R4.
- R6: bus_ready is high in the first cycle of every access except a 32-bit colour port write, which asserts bus_ready in its fourth cycle. The requester holds the request stable until ready.
- R7: Reads at any offset return zero on bus_rdata.
- R8: Each component written sets redraw_req. redraw_clr drops it on the next edge, but a component write in the same cycle wins over the clear.
- R9: After reset every palette byte is zero, the pointer is 0, the phase is red and redraw_req is 1.
- R10: pix_rgb is {red, green, blue} in bits 23:16, 15:8 and 7:0. It shows the entry addressed by pix_idx at the previous clock edge.
- R11: A component written at one edge is returned by a lookup sampled at the very next edge.
- R12: Writes to offsets other than 0x00 and 0x04 change neither the palette, the pointer, the phase nor redraw_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_addr | input | 5 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_ready | output | 1 | Access completes at this edge |
| redraw_clr | input | 1 | Drops the redraw request |
| redraw_req | output | 1 | Full redraw requested |
| pix_idx | input | 8 | Pixel code to look up |
| pix_rgb | output | 24 | Packed colour of the pixel code |

## Verification
A wrong phase or pointer stays hidden until the next component is written. It then shows up as a byte in the wrong colour field or in the wrong entry, and the pixel port exposes it one cycle after a lookup of that entry. Runs of stream writes that cross the 255-to-0 wrap, pointer reloads in the middle of an entry, and wide writes that start at green or blue make a slip visible within a few accesses. A wrong word unpacking order shows as swapped colour fields in four consecutive components. A miscounted busy window shows directly as a ready that comes too early or too late.

// File: rtl/clut_pkg.sv
package clut_pkg;
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 8,
    parameter int COMP_W    = 8,
    parameter logic [ADDR_W-1:0] OFF_PTR = 'h0,
    parameter logic [ADDR_W-1:0] OFF_COL = 'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              redraw_clr,
    output logic              ready,
    output logic              redraw,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output phase_e            wr_comp,
    output logic [COMP_W-1:0] wr_byte
);
    localparam int LANES = DATA_W / COMP_W;
    localparam int CNT_W = (LANES > 2) ? $clog2(LANES) : 1;
    localparam int SH_W  = DATA_W - COMP_W;

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  left;
        logic [SH_W-1:0]   shreg;
        phase_e            phase;
        logic [IDX_W-1:0]  idx;
        logic              redraw;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_byte = '0;
        ready   = 1'b0;
        if (st_q.busy) begin
            wr_en      = 1'b1;
            wr_byte    = st_q.shreg[SH_W-1 -: COMP_W];
            st_d.shreg = st_q.shreg << COMP_W;
            st_d.left  = st_q.left - CNT_W'(1);
            if (st_q.left == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                ready     = 1'b1;
            end
        end else if (req) begin
            ready = 1'b1;
            if (we && addr == OFF_PTR) begin
                st_d.idx   = wdata[IDX_W-1:0];
                st_d.phase = PH_RED;
            end else if (we && addr == OFF_COL) begin
                wr_en = 1'b1;
                if (wide) begin
                    wr_byte    = wdata[DATA_W-1 -: COMP_W];
                    st_d.shreg = wdata[SH_W-1:0];
                    st_d.left  = CNT_W'(LANES - 1);
                    st_d.busy  = 1'b1;
                    ready      = 1'b0;
                end else begin
                    wr_byte = wdata[COMP_W-1:0];
                end
            end
        end
        wr_idx  = st_q.idx;
        wr_comp = st_q.phase;
        if (wr_en) begin
            case (st_q.phase)
                PH_RED:  st_d.phase = PH_GRN;
                PH_GRN:  st_d.phase = PH_BLU;
                default: begin
                    st_d.phase = PH_RED;
                    st_d.idx   = st_q.idx + IDX_W'(1);
                end
            endcase
        end
        if (wr_en)           st_d.redraw = 1'b1;
        else if (redraw_clr) st_d.redraw = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.phase  <= PH_RED;
            st_q.redraw <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign redraw = st_q.redraw;
endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  phase_e              wr_comp,
    input  logic [COMP_W-1:0]   wr_byte,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic [3*COMP_W-1:0] pix_rgb
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [3*COMP_W-1:0] ent_vec [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [COMP_W-1:0] red_q, grn_q, blu_q;
        logic              hit;
        assign hit = wr_en && (wr_idx == IDX_W'(e));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                red_q <= '0;
                grn_q <= '0;
                blu_q <= '0;
            end else if (hit) begin
                case (wr_comp)
                    PH_RED:  red_q <= wr_byte;
                    PH_GRN:  grn_q <= wr_byte;
                    default: blu_q <= wr_byte;
                endcase
            end
        end
        assign ent_vec[e] = {red_q, grn_q, blu_q};
    end

    logic [3*COMP_W-1:0] rgb_d, rgb_q;

    always_comb begin
        rgb_d = ent_vec[pix_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rgb_q <= '0;
        else        rgb_q <= rgb_d;
    end

    assign pix_rgb = rgb_q;
endmodule

// File: rtl/clut_dac.sv
module clut_dac
    import clut_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic                bus_wide,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_ready,
    input  logic                redraw_clr,
    output logic                redraw_req,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic [3*COMP_W-1:0] pix_rgb
);
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    phase_e            wr_comp;
    logic [COMP_W-1:0] wr_byte;

    clut_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .COMP_W (COMP_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (bus_req),
        .we         (bus_we),
        .wide       (bus_wide),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .redraw_clr (redraw_clr),
        .ready      (bus_ready),
        .redraw     (redraw_req),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_comp    (wr_comp),
        .wr_byte    (wr_byte)
    );

    clut_store #(
        .IDX_W  (IDX_W),
        .COMP_W (COMP_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_comp (wr_comp),
        .wr_byte (wr_byte),
        .pix_idx (pix_idx),
        .pix_rgb (pix_rgb)
    );

    assign bus_rdata = '0;
endmodule

// File: rtl/clut_dac_chk.sv
module clut_dac_chk
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input phase_e           wr_comp,
    input logic             bus_ready,
    input logic             redraw_req
);
    AST_RED_TO_GRN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_comp == PH_RED |=> !wr_en || wr_comp == PH_GRN); // R3
    AST_GRN_TO_BLU: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_comp == PH_GRN |=> !wr_en || wr_comp == PH_BLU); // R3
    AST_BLU_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_comp == PH_BLU |=> !wr_en ||
        (wr_comp == PH_RED && wr_idx == $past(wr_idx) + IDX_W'(1))); // R4
    AST_WORD_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !bus_ready |=> wr_en); // R6
    AST_REDRAW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> redraw_req); // R8
    AST_RESET_REDRAW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> redraw_req); // R9
endmodule

bind clut_dac clut_dac_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_comp    (wr_comp),
    .bus_ready  (bus_ready),
    .redraw_req (redraw_req)
);

// File: tb/clut_dac_bench.sv
module clut_dac_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_wide = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        redraw_clr = 1'b0;
    logic        redraw_req;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    always #5 clk = ~clk;

    clut_dac u_clut_dac (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .redraw_clr(redraw_clr),
        .redraw_req(redraw_req), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mr [256];
    logic [7:0] mg [256];
    logic [7:0] mb [256];
    logic [7:0] midx;
    int         mph;

    function automatic logic [23:0] model_rgb(input logic [7:0] i);
        return {mr[i], mg[i], mb[i]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_byte(input logic [7:0] b);
        case (mph)
            0: begin mr[midx] = b; mph = 1; end
            1: begin mg[midx] = b; mph = 2; end
            default: begin mb[midx] = b; midx = midx + 8'd1; mph = 0; end
        endcase
    endtask

    // Starts and ends at a falling edge.
    task automatic bus_op(input logic [4:0] a, input logic we, input logic wide,
                          input logic [31:0] d, output int cyc, output logic [31:0] rd);
        logic rdy;
        bus_req = 1'b1; bus_addr = a; bus_we = we; bus_wide = wide; bus_wdata = d;
        cyc = 0; rd = '0;
        forever begin
            #1;
            rdy = bus_ready;
            rd  = bus_rdata;
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (rdy || cyc > 8) break;
        end
        bus_req = 1'b0;
    endtask

    task automatic wr_ptr(input logic [7:0] v);
        int c; logic [31:0] rd;
        bus_op(5'h00, 1'b1, $urandom_range(0, 1), {$urandom_range(0, 255), 16'h0, v}, c, rd);
        chk(c == 1, "R1 pointer write ready", c, 1);
        midx = v; mph = 0;
    endtask

    task automatic wr_byte(input logic [7:0] v);
        int c; logic [31:0] rd;
        bus_op(5'h04, 1'b1, 1'b0, {$urandom_range(0, 65535), $urandom_range(0, 255), v}, c, rd);
        chk(c == 1, "R6 byte colour ready", c, 1);
        model_byte(v); // R2: upper bits ignored
    endtask

    task automatic wr_word(input logic [31:0] v);
        int c; logic [31:0] rd;
        bus_op(5'h04, 1'b1, 1'b1, v, c, rd);
        chk(c == 4, "R6 word colour ready in fourth cycle", c, 4);
        model_byte(v[31:24]); model_byte(v[23:16]); // R5 order
        model_byte(v[15:8]);  model_byte(v[7:0]);
    endtask

    task automatic wr_other(input logic [4:0] a);
        int c; logic [31:0] rd;
        bus_op(a, 1'b1, $urandom_range(0, 1), $urandom, c, rd);
        chk(c == 1, "R12 other offset ready", c, 1);
    endtask

    task automatic rd_any(input logic [4:0] a);
        int c; logic [31:0] rd;
        bus_op(a, 1'b0, $urandom_range(0, 1), $urandom, c, rd);
        chk(rd == 0, "R7 read returns zero", rd, 0);
        chk(c == 1, "R6 read ready", c, 1);
    endtask

    task automatic look(input logic [7:0] i, input string tag);
        pix_idx = i;
        @(posedge clk);
        @(negedge clk);
        chk(pix_rgb == model_rgb(i), tag, {8'h0, pix_rgb}, {8'h0, model_rgb(i)});
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [4:0] oa;
        logic [7:0] li;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 256; i++) begin mr[i] = 0; mg[i] = 0; mb[i] = 0; end
        midx = 0; mph = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        chk(redraw_req == 1'b1, "R9 redraw after reset", redraw_req, 1);
        look(8'h00, "R9 entry 0 zero");
        look(8'hFF, "R9 entry 255 zero");
        rd_any(5'h00);
        rd_any(5'h04);
        // R9: pointer 0 and phase red after reset
        wr_byte(8'hA1); wr_byte(8'hB2); wr_byte(8'hC3);
        look(8'h00, "R9 R3 first triple lands in entry 0");
        // R8 clear and set
        redraw_clr = 1'b1; @(posedge clk); @(negedge clk); redraw_clr = 1'b0;
        chk(redraw_req == 1'b0, "R8 clear drops redraw", redraw_req, 0);
        wr_other(5'h08); wr_other(5'h10);
        chk(redraw_req == 1'b0, "R12 other write leaves redraw", redraw_req, 0);
        look(8'h01, "R12 palette untouched");
        redraw_clr = 1'b1;
        wr_byte(8'h11);
        redraw_clr = 1'b0;
        chk(redraw_req == 1'b1, "R8 write wins over clear", redraw_req, 1);
        // R11 next-cycle visibility
        look(8'h01, "R11 red visible next cycle");
        // R1 reload mid entry, R4 wrap
        wr_ptr(8'hFE);
        wr_word(32'h01020304);
        look(8'hFE, "R5 word order entry FE");
        wr_word(32'h05060708);
        look(8'hFF, "R4 entry FF");
        look(8'h00, "R4 R5 wrap into entry 0");
        wr_ptr(8'h10); wr_byte(8'h55); wr_ptr(8'h20); wr_byte(8'h66);
        look(8'h10, "R1 reload resets phase");
        look(8'h20, "R1 new pointer");
        // random mix
        for (int n = 0; n < 400; n++) begin
            case ($urandom_range(0, 6))
                0: wr_ptr(8'($urandom));
                1, 2: wr_byte(8'($urandom));
                3: wr_word($urandom);
                4: begin
                    oa = 5'($urandom_range(0, 31));
                    if (oa == 5'h00 || oa == 5'h04) oa = 5'h1C;
                    wr_other(oa);
                end
                5: rd_any(5'($urandom));
                default: begin
                    li = (($urandom_range(0, 1)) != 0) ? midx : 8'($urandom);
                    look(li, "R10 random lookup");
                end
            endcase
        end
        for (int i = 0; i < 256; i++) look(8'(i), "R10 full sweep");
        report();
        $finish;
    end
endmodule